// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit with Per-Bit Auto-Masking

This block keeps the interrupt state for a device with up to sixteen interrupt sources. A cause register records which sources have fired. A mask register selects which of them may interrupt. A pending vector, the AND of the two, is handed to whatever logic sends the interrupt. Hardware events set cause bits. Software clears cause bits by writing ones to the cause address, and it can raise cause bits through a separate cause-set address. Mask bits are opened through a mask-set address and closed through a mask-clear address.

A third register, the auto-mask enable, selects per bit whether the mask follows events without software touching it directly. In the write-driven mode, a cause clear also closes the matching mask bits, and a cause set also opens them. This mode lets a handler finish its work with one write. In the generation-driven mode, which is active only while message mode and the global auto-mask flag are both set, an interrupt-generated pulse for a cause closes that cause's mask bit. Software then never needs to read the cause register.

Bus handshakes, message transport and moderation timing belong to neighbouring blocks. Register access is a single-cycle write strobe plus a combinational read port.

Top module: `irq_cause_mask`

## Requirements
- R1: After synchronous reset the cause, mask and auto-mask enable registers are all zero, and the pending output is zero.
- R2: Reading address 0 or 1 returns the cause register. Reading address 2 or 3 returns the mask. Reading address 4 returns the auto-mask enable register. Any other address reads zero. Bits at or above NUM_CAUSE always read zero.
- R3: A write to address 0 clears every cause bit whose data bit is 1. Data bits that are 0 leave their cause bits unchanged.
- R4: A write to address 1 sets every cause bit whose data bit is 1. Data bits that are 0 leave their cause bits unchanged.
- R5: A hardware event pulse sets its cause bit on the next clock edge. If an event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R6: A write to address 2 sets the mask bits whose data bit is 1. A write to address 3 clears them. Zero data bits leave the mask unchanged.
- R7: Address 4 is a plain read/write register holding the auto-mask enable bits. Data bits at or above NUM_CAUSE are dropped.
- R8: The pending output equals the cause register ANDed with the mask register.
- R9: Unless message mode and the global auto-mask flag are both 1, the following holds for every bit whose auto-mask enable bit is 1: a cause clear at address 0 also clears the mask bit, and a cause set at address 1 also sets the mask bit.
- R10: While message mode and the global auto-mask flag are both 1, an interrupt-generated pulse clears the mask bit of every cause whose auto-mask enable bit is 1. In this mode, cause writes leave the mask untouched. Outside this mode, interrupt-generated pulses have no effect.
- R11: If a mask bit is set and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | DATA_W | Combinational read data |
| hwEvent | input | NUM_CAUSE | Hardware cause pulses |
| msgMode | input | 1 | Message (vector) interrupt mode active |
| autoMaskGlobal | input | 1 | Global enable for generation-driven auto-masking |
| intGenerated | input | NUM_CAUSE | Per-cause pulse: an interrupt was just generated |
| pendingOut | output | NUM_CAUSE | Masked pending causes |

## Verification
The bench drives a hardware event into a bit in the same cycle that software clears it. A design that gives the clear priority would drop that event. It checks that auto-masking follows the mode split. The case that matters most is message mode with the global flag low, where a cause write must still move the mask. Also in that case, an interrupt-generated pulse must do nothing. A design that decodes the mode from only one of the two flags would fail one of these checks. Other checks cover zero data bits, unused upper data bits, unmapped read addresses, and a mask-set write that collides with a generation-driven clear. A design that gives the clear priority in that last case would leave the cause masked.

// File: rtl/irq_cause_mask_pkg.sv
package irq_cause_mask_pkg;

  // register addresses, decoded by the write controller and the readback mux
  localparam int RegCause    = 0;
  localparam int RegCauseSet = 1;
  localparam int RegMaskSet  = 2;
  localparam int RegMaskClr  = 3;
  localparam int RegAutoMask = 4;

  // per-cause update strobes from control to datapath
  typedef struct packed {
    logic causeClr;
    logic causeSet;
    logic maskSet;
    logic maskClr;
  } bitStrobe_t;

endpackage

// File: rtl/irq_cause_mask_ctrl.sv
module irq_cause_mask_ctrl
  import irq_cause_mask_pkg::*;
#(
  parameter int NUM_CAUSE = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic                              msgMode,
  input  logic                              autoMaskGlobal,
  input  logic [NUM_CAUSE-1:0]              intGenerated,
  input  logic [NUM_CAUSE-1:0]              aemQ,
  output bitStrobe_t [NUM_CAUSE-1:0]        strobeVec,
  output logic                              aemWr
);

  logic hitCause, hitCauseSet, hitMaskSet, hitMaskClr;
  logic genMode;
  logic [NUM_CAUSE-1:0] dataLo;

  assign dataLo = wrData[NUM_CAUSE-1:0];

  generate
    if (DATA_W > NUM_CAUSE) begin : g_hiBits
      logic unusedHi;
      assign unusedHi = ^wrData[DATA_W-1:NUM_CAUSE];
    end
  endgenerate

  assign hitCause    = wrEn && (wrAddr == ADDR_W'(RegCause));
  assign hitCauseSet = wrEn && (wrAddr == ADDR_W'(RegCauseSet));
  assign hitMaskSet  = wrEn && (wrAddr == ADDR_W'(RegMaskSet));
  assign hitMaskClr  = wrEn && (wrAddr == ADDR_W'(RegMaskClr));
  assign aemWr       = wrEn && (wrAddr == ADDR_W'(RegAutoMask));

  // generation-driven masking replaces write-driven masking
  assign genMode = msgMode && autoMaskGlobal;

  generate
    for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_bit
      logic cClr, cSet;
      assign cClr = hitCause && dataLo[i];
      assign cSet = hitCauseSet && dataLo[i];
      always_comb begin
        strobeVec[i].causeClr = cClr;
        strobeVec[i].causeSet = cSet;
        strobeVec[i].maskSet  = (hitMaskSet && dataLo[i]) ||
                                (!genMode && aemQ[i] && cSet);
        strobeVec[i].maskClr  = (hitMaskClr && dataLo[i]) ||
                                (!genMode && aemQ[i] && cClr) ||
                                (genMode && aemQ[i] && intGenerated[i]);
      end
    end
  endgenerate

endmodule

// File: rtl/irq_cause_mask_dp.sv
module irq_cause_mask_dp
  import irq_cause_mask_pkg::*;
#(
  parameter int NUM_CAUSE = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  bitStrobe_t [NUM_CAUSE-1:0] strobeVec,
  input  logic                       aemWr,
  input  logic [NUM_CAUSE-1:0]       aemData,
  input  logic [NUM_CAUSE-1:0]       hwEvent,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic [NUM_CAUSE-1:0]       causeQ,
  output logic [NUM_CAUSE-1:0]       maskQ,
  output logic [NUM_CAUSE-1:0]       aemQ,
  output logic [NUM_CAUSE-1:0]       pendingOut,
  output logic [DATA_W-1:0]          rdData
);

  generate
    for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          causeQ[i] <= 1'b0;
          maskQ[i]  <= 1'b0;
        end else begin
          // hardware event and set beat a clear
          causeQ[i] <= hwEvent[i] | strobeVec[i].causeSet |
                       (causeQ[i] & ~strobeVec[i].causeClr);
          // set beats clear
          maskQ[i]  <= strobeVec[i].maskSet |
                       (maskQ[i] & ~strobeVec[i].maskClr);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) aemQ <= '0;
    else if (aemWr) aemQ <= aemData;
  end

  assign pendingOut = causeQ & maskQ;

  always_comb begin
    case (rdAddr)
      ADDR_W'(RegCause),
      ADDR_W'(RegCauseSet): rdData = DATA_W'(causeQ);
      ADDR_W'(RegMaskSet),
      ADDR_W'(RegMaskClr):  rdData = DATA_W'(maskQ);
      ADDR_W'(RegAutoMask): rdData = DATA_W'(aemQ);
      default:              rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask
  import irq_cause_mask_pkg::*;
#(
  parameter int NUM_CAUSE = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_CAUSE-1:0] hwEvent,
  input  logic                 msgMode,
  input  logic                 autoMaskGlobal,
  input  logic [NUM_CAUSE-1:0] intGenerated,
  output logic [NUM_CAUSE-1:0] pendingOut
);

  bitStrobe_t [NUM_CAUSE-1:0] strobeVec;
  logic                       aemWr;
  logic [NUM_CAUSE-1:0]       causeQ, maskQ, aemQ;

  irq_cause_mask_ctrl #(
    .NUM_CAUSE(NUM_CAUSE), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .msgMode(msgMode), .autoMaskGlobal(autoMaskGlobal),
    .intGenerated(intGenerated), .aemQ(aemQ),
    .strobeVec(strobeVec), .aemWr(aemWr)
  );

  irq_cause_mask_dp #(
    .NUM_CAUSE(NUM_CAUSE), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobeVec(strobeVec), .aemWr(aemWr),
    .aemData(wrData[NUM_CAUSE-1:0]), .hwEvent(hwEvent), .rdAddr(rdAddr),
    .causeQ(causeQ), .maskQ(maskQ), .aemQ(aemQ),
    .pendingOut(pendingOut), .rdData(rdData)
  );

endmodule

// File: rtl/irq_cause_mask_chk.sv
module irq_cause_mask_chk
  import irq_cause_mask_pkg::*;
#(
  parameter int NUM_CAUSE = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    wrAddr,
  input logic [DATA_W-1:0]    wrData,
  input logic [NUM_CAUSE-1:0] hwEvent,
  input logic                 msgMode,
  input logic                 autoMaskGlobal,
  input logic [NUM_CAUSE-1:0] intGenerated,
  input logic [NUM_CAUSE-1:0] causeQ,
  input logic [NUM_CAUSE-1:0] maskQ,
  input logic [NUM_CAUSE-1:0] aemQ
);

  logic [NUM_CAUSE-1:0] wrLo;
  logic unusedChkHi;
  assign wrLo = wrData[NUM_CAUSE-1:0];
  assign unusedChkHi = ^wrData;

  a_r3_cause_clear: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_W'(RegCause)) |=>
      ((causeQ & $past(wrLo) & ~$past(hwEvent)) == '0));

  a_r4_cause_set: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_W'(RegCauseSet)) |=>
      ((causeQ & $past(wrLo)) == $past(wrLo)));

  a_r5_hw_sets: assert property (@(posedge clk) disable iff (rst)
    (hwEvent != '0) |=> ((causeQ & $past(hwEvent)) == $past(hwEvent)));

  a_r6_mask_set: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_W'(RegMaskSet)) |=>
      ((maskQ & $past(wrLo)) == $past(wrLo)));

  a_r6_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !(msgMode && autoMaskGlobal && intGenerated != '0)) |=>
      $stable(maskQ));

  a_r7_aem_hold: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && wrAddr == ADDR_W'(RegAutoMask)) |=> $stable(aemQ));

  a_r10_gen_clear: assert property (@(posedge clk) disable iff (rst)
    (msgMode && autoMaskGlobal && (intGenerated & aemQ) != '0 &&
     !(wrEn && wrAddr == ADDR_W'(RegMaskSet))) |=>
      ((maskQ & $past(intGenerated & aemQ)) == '0));

endmodule

bind irq_cause_mask irq_cause_mask_chk #(
  .NUM_CAUSE(NUM_CAUSE), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .hwEvent(hwEvent), .msgMode(msgMode), .autoMaskGlobal(autoMaskGlobal),
  .intGenerated(intGenerated), .causeQ(causeQ), .maskQ(maskQ), .aemQ(aemQ)
);

// File: tb/sim_irq_cause_mask.sv
module sim_irq_cause_mask;

  localparam int ClkPeriod = 10;
  localparam int NC = 16;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic [NC-1:0] hwEvent = '0;
  logic          msgMode = 1'b0;
  logic          autoMaskGlobal = 1'b0;
  logic [NC-1:0] intGenerated = '0;
  logic [NC-1:0] pendingOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  irq_cause_mask #(.NUM_CAUSE(NC), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .hwEvent(hwEvent), .msgMode(msgMode),
    .autoMaskGlobal(autoMaskGlobal), .intGenerated(intGenerated),
    .pendingOut(pendingOut)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readCheck(input string tag, input int addr, input logic [DW-1:0] exp);
    rdAddr = AW'(addr);
    #1;
    check(tag, rdData, exp);
  endtask

  // one clock with the given stimulus; returns at the following negedge
  task automatic cycle(input bit we, input int addr, input logic [DW-1:0] data,
                       input logic [NC-1:0] hw, input logic [NC-1:0] gen);
    @(negedge clk);
    wrEn = we; wrAddr = AW'(addr); wrData = data;
    hwEvent = hw; intGenerated = gen;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; hwEvent = '0; intGenerated = '0;
  endtask

  task automatic testReset();
    readCheck("R1 cause", 0, 0);
    readCheck("R1 mask", 2, 0);
    readCheck("R1 aem", 4, 0);
    check("R1 pending", DW'(pendingOut), 0);
  endtask

  task automatic testCauseSetMask();
    cycle(1, 1, 32'h00F0, 0, 0);
    readCheck("R4 cause set", 1, 32'h00F0);
    readCheck("R2 cause via addr0", 0, 32'h00F0);
    check("R8 pending masked", DW'(pendingOut), 0);
    cycle(1, 2, 32'h0030, 0, 0);
    cycle(1, 2, 32'h0000, 0, 0);
    readCheck("R6 mask set, zero no effect", 3, 32'h0030);
    check("R8 pending", DW'(pendingOut), 32'h0030);
  endtask

  task automatic testCauseClear();
    cycle(1, 0, 32'h0050, 0, 0);
    readCheck("R3 cause clear", 0, 32'h00A0);
    readCheck("R9 aem zero keeps mask", 2, 32'h0030);
    check("R8 pending after clear", DW'(pendingOut), 32'h0020);
  endtask

  task automatic testHwEvents();
    cycle(0, 0, 0, 16'h0101, 0);
    readCheck("R5 hw event", 0, 32'h01A1);
    cycle(1, 0, 32'h0101, 16'h0001, 0);
    readCheck("R5 hw beats clear", 0, 32'h00A1);
  endtask

  task automatic testMaskClear();
    cycle(1, 3, 32'h0010, 0, 0);
    cycle(1, 3, 32'h0000, 0, 0);
    readCheck("R6 mask clear", 2, 32'h0020);
    check("R8 pending", DW'(pendingOut), 32'h0020);
  endtask

  task automatic testAem();
    cycle(1, 4, 32'hFFFF_0F0F, 0, 0);
    readCheck("R7 aem write, upper dropped", 4, 32'h0F0F);
  endtask

  task automatic testWriteAutoMask();
    cycle(1, 1, 32'h0303, 0, 0);
    readCheck("R9 cause after set", 0, 32'h03A3);
    readCheck("R9 mask follows set", 2, 32'h0323);
    cycle(1, 0, 32'h0101, 0, 0);
    readCheck("R9 mask follows clear", 2, 32'h0222);
    check("R8 pending", DW'(pendingOut), 32'h0222);
    msgMode = 1'b1;
    cycle(1, 0, 32'h0002, 0, 0);
    readCheck("R9 msgMode alone keeps write mode", 2, 32'h0220);
    cycle(0, 0, 0, 0, 16'h0200);
    readCheck("R10 gen ignored outside gen mode", 2, 32'h0220);
  endtask

  task automatic testGenAutoMask();
    autoMaskGlobal = 1'b1;
    cycle(1, 1, 32'h0004, 0, 0);
    readCheck("R10 cause set in gen mode", 0, 32'h02A4);
    readCheck("R10 set leaves mask", 2, 32'h0220);
    cycle(1, 0, 32'h0004, 0, 0);
    readCheck("R10 clear leaves mask", 2, 32'h0220);
    cycle(0, 0, 0, 0, 16'h0220);
    readCheck("R10 gen clears aem bits only", 2, 32'h0020);
    check("R8 pending after gen", DW'(pendingOut), 32'h0020);
    cycle(1, 2, 32'h0100, 0, 16'h0100);
    readCheck("R11 set beats gen clear", 2, 32'h0120);
  endtask

  task automatic testUnmapped();
    readCheck("R2 unmapped addr5", 5, 0);
    readCheck("R2 unmapped addr7", 7, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testCauseSetMask();
    testCauseClear();
    testHwEvents();
    testMaskClear();
    testAem();
    testWriteAutoMask();
    testGenAutoMask();
    testUnmapped();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(ClkPeriod * 20000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule